// File: doc/BRIEF.md
# Predicated Lane-Wise Multiply-High Unit

This unit is a vector datapath stage that works on two 128-bit operand vectors. A two-bit size code cuts both vectors into equal lanes of 8, 16, 32 or 64 bits, and the code can change from one cycle to the next. In every active lane the unit forms the complete double-width product of the two lane values and keeps only the upper half. A lane counts as signed or unsigned according to a one-bit mode input, and the default is signed.

A 16-bit predicate carries one bit per byte and chooses which lanes take part. A lane whose predicate is clear returns the first operand's lane unchanged. The output vector is therefore the first operand with the active lanes overwritten, so it can be written back into the register that supplied that operand.

The pipeline is fixed at three register stages. An input accepted with `in_valid` produces its result with `out_valid` two cycles after the edge that accepted it, and a new input can be accepted on every cycle.

Top module: `vmh_unit`

## Requirements
- R1: `in_size` sets the lane width to 8 << code bits. Code 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The vector holds 128 / width lanes, and lane e occupies bits [e*width +: width].
- R2: With `in_unsigned`=0, each active lane holds bits [2w-1:w] of the signed product of the two lanes taken as two's-complement values.
- R3: With `in_unsigned`=1, each active lane holds bits [2w-1:w] of the product of the two lanes taken as unsigned values.
- R4: Lane e is active exactly when predicate bit e*(width/8) is 1. The other predicate bits inside a lane have no effect.
- R5: An inactive lane outputs the first operand's lane value unchanged.
- R6: The most negative lane value multiplied by itself in signed mode gives the exact high half: 0x40 for 8-bit lanes and 0x4000_0000_0000_0000 for 64-bit lanes.
- R7: `out_valid` is high in the cycle that follows exactly two clock edges after the edge that sampled `in_valid`=1, and low otherwise. Inputs presented on consecutive cycles each produce a result on consecutive cycles.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_vec` to zero at the next edge.
- R9: `out_vec` keeps its previous value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present this cycle |
| in_op1 | input | 128 | First operand, merge source for inactive lanes |
| in_op2 | input | 128 | Second operand |
| in_pred | input | 16 | Byte-granular lane predicate |
| in_size | input | 2 | Lane size code |
| in_unsigned | input | 1 | 1 = unsigned lanes, 0 = signed |
| out_valid | output | 1 | Result present this cycle |
| out_vec | output | 128 | Merged result vector |

## Verification
Two faults show up at the ports within one result. A lane multiplier with a wrong sign-extension bit corrupts the high byte of the affected lanes. A predicate decode that reads the wrong byte bit either replaces an operand lane with a product or leaves a product out. Both appear on the very `out_valid` cycle that belongs to the faulty input. A wrong valid pipeline shows up as `out_valid` arriving one cycle early or late against the streamed inputs. A missing output enable shows up as `out_vec` changing during an idle cycle. The exhaustive 8-bit sweep exposes any operand pair that the wide lanes would hide.

// File: rtl/vmh_pkg.sv
package vmh_pkg;
  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned SIZE_W    = $clog2(NUM_SIZES);

  typedef enum logic [SIZE_W-1:0] {
    LANE_B = 2'd0,
    LANE_H = 2'd1,
    LANE_W = 2'd2,
    LANE_D = 2'd3
  } lane_size_e;

  function automatic int unsigned lane_bits(input int unsigned code);
    return 8 << code;
  endfunction
endpackage

// File: rtl/vmh_lane_mul.sv
// One lane multiplier: extends each operand by one bit (sign or zero),
// multiplies, and registers the upper half of the 2*LW-bit product.
module vmh_lane_mul #(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          uns,
  output logic [LW-1:0] hi
);
  localparam int unsigned EW = LW + 1;
  localparam int unsigned PW = 2 * EW;

  logic signed [EW-1:0] ea, eb;
  logic signed [PW-1:0] prod;
  logic                 unused_prod_bits;

  assign ea   = $signed({~uns & a[LW-1], a});
  assign eb   = $signed({~uns & b[LW-1], b});
  assign prod = ea * eb;
  assign unused_prod_bits = ^{prod[PW-1:2*LW], prod[LW-1:0]};

  always_ff @(posedge clk) begin
    hi <= prod[2*LW-1:LW];
  end
endmodule

// File: rtl/vmh_merge.sv
// Picks per byte either the product high half of the selected lane size
// or the first-operand byte, using the predicate bit at the lane's lowest byte.
module vmh_merge
  import vmh_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned PRED_W = VEC_W / 8
) (
  input  logic [NUM_SIZES-1:0][VEC_W-1:0] hi_all,
  input  logic [VEC_W-1:0]                op1,
  input  logic [PRED_W-1:0]               pred,
  input  logic [SIZE_W-1:0]               size,
  output logic [VEC_W-1:0]                merged
);
  logic [NUM_SIZES-1:0][PRED_W-1:0] act;

  for (genvar bt = 0; bt < PRED_W; bt++) begin : g_byte
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
      localparam int unsigned LEAD = bt - (bt % (1 << s));
      assign act[s][bt] = pred[LEAD];
    end
    always_comb begin
      merged[bt*8 +: 8] = act[size][bt] ? hi_all[size][bt*8 +: 8] : op1[bt*8 +: 8];
    end
  end
endmodule

// File: rtl/vmh_unit.sv
// Predicated lane-wise multiply-high. Stage A captures inputs, stage B holds
// lane products, stage C is the merged registered output.
module vmh_unit
  import vmh_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned PRED_W = VEC_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_op1,
  input  logic [VEC_W-1:0]  in_op2,
  input  logic [PRED_W-1:0] in_pred,
  input  logic [1:0]        in_size,
  input  logic              in_unsigned,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_vec
);
  // stage A
  logic              a_valid, a_uns;
  logic [VEC_W-1:0]  a_op1, a_op2;
  logic [PRED_W-1:0] a_pred;
  logic [SIZE_W-1:0] a_size;
  // stage B
  logic              b_valid;
  logic [VEC_W-1:0]  b_op1;
  logic [PRED_W-1:0] b_pred;
  logic [SIZE_W-1:0] b_size;
  logic [NUM_SIZES-1:0][VEC_W-1:0] hi_all;
  logic [VEC_W-1:0]  merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      b_valid <= 1'b0;
    end else begin
      a_valid <= in_valid;
      b_valid <= a_valid;
    end
  end

  always_ff @(posedge clk) begin
    a_op1  <= in_op1;
    a_op2  <= in_op2;
    a_pred <= in_pred;
    a_size <= in_size;
    a_uns  <= in_unsigned;
    b_op1  <= a_op1;
    b_pred <= a_pred;
    b_size <= a_size;
  end

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int unsigned LW    = lane_bits(s);
    localparam int unsigned LANES = VEC_W / LW;
    for (genvar e = 0; e < LANES; e++) begin : g_lane
      vmh_lane_mul #(.LW(LW)) u_mul (
        .clk (clk),
        .a   (a_op1[e*LW +: LW]),
        .b   (a_op2[e*LW +: LW]),
        .uns (a_uns),
        .hi  (hi_all[s][e*LW +: LW])
      );
    end
  end

  vmh_merge #(.VEC_W(VEC_W), .PRED_W(PRED_W)) u_merge (
    .hi_all (hi_all),
    .op1    (b_op1),
    .pred   (b_pred),
    .size   (b_size),
    .merged (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= b_valid;
      if (b_valid) out_vec <= merged;
    end
  end
endmodule

// File: rtl/vmh_unit_chk.sv
module vmh_unit_chk #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned PRED_W = VEC_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [VEC_W-1:0]  in_op1,
  input logic [VEC_W-1:0]  in_op2,
  input logic [PRED_W-1:0] in_pred,
  input logic [1:0]        in_size,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_vec
);
  logic [2:0]              d_v;
  logic [2:0][VEC_W-1:0]   d_op1, d_op2;
  logic [2:0][PRED_W-1:0]  d_pred;
  logic [2:0][1:0]         d_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_v <= '0;
    end else begin
      d_v <= {d_v[1:0], in_valid};
    end
    d_op1  <= {d_op1[1:0], in_op1};
    d_op2  <= {d_op2[1:0], in_op2};
    d_pred <= {d_pred[1:0], in_pred};
    d_size <= {d_size[1:0], in_size};
  end

  function automatic int unsigned lead_byte(input logic [1:0] sz, input int unsigned bt);
    return bt - (bt % (1 << sz));
  endfunction

  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == d_v[2]);

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_vec == '0));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_vec));

  for (genvar bt = 0; bt < PRED_W; bt++) begin : g_chk
    a_r5_passthru: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !d_pred[2][lead_byte(d_size[2], bt)])
        |-> out_vec[bt*8 +: 8] == d_op1[2][bt*8 +: 8]);

    a_r2_zero_operand: assert property (@(posedge clk) disable iff (rst)
      (out_valid && d_op2[2] == '0 && d_pred[2][lead_byte(d_size[2], bt)])
        |-> out_vec[bt*8 +: 8] == 8'h00);
  end
endmodule

bind vmh_unit vmh_unit_chk #(.VEC_W(VEC_W), .PRED_W(PRED_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_op1    (in_op1),
  .in_op2    (in_op2),
  .in_pred   (in_pred),
  .in_size   (in_size),
  .out_valid (out_valid),
  .out_vec   (out_vec)
);

// File: tb/vmh_unit_test.sv
`timescale 1ns/1ps
module vmh_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_op1 = '0, in_op2 = '0;
  logic [15:0]  in_pred = '0;
  logic [1:0]   in_size = '0;
  logic         in_unsigned = 1'b0;
  logic         out_valid;
  logic [127:0] out_vec;

  int checks = 0;
  int errors = 0;

  logic         p_v [3];
  logic [127:0] p_e [3];
  string        p_t [3];
  logic [127:0] last_out;
  logic [63:0]  rs = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  vmh_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op1(in_op1), .in_op2(in_op2),
    .in_pred(in_pred), .in_size(in_size), .in_unsigned(in_unsigned),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [127:0] ref_mulh(input logic [127:0] a1, input logic [127:0] a2,
                                            input logic [15:0] pr, input logic [1:0] sz,
                                            input logic uns);
    int lw = 8 << sz;
    int n  = 128 / lw;
    logic [127:0] r = '0;
    logic [127:0] m = (128'd1 << lw) - 128'd1;
    for (int e = 0; e < n; e++) begin
      logic [127:0] ua, ub, hi;
      logic signed [135:0] sa, sb, prod, sh;
      ua = (a1 >> (e * lw)) & m;
      ub = (a2 >> (e * lw)) & m;
      sa = {8'b0, ua};
      sb = {8'b0, ub};
      if (!uns && ua[lw-1]) sa = sa - (136'sd1 <<< lw);
      if (!uns && ub[lw-1]) sb = sb - (136'sd1 <<< lw);
      prod = sa * sb;
      sh = prod >>> lw;
      hi = sh[127:0] & m;
      if (pr[e * (lw / 8)]) r = r | (hi << (e * lw));
      else                  r = r | (ua << (e * lw));
    end
    return r;
  endfunction

  function automatic logic [63:0] xs(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: check outputs for the input driven three negedges ago, then drive.
  task automatic step(input logic v, input logic [127:0] a1, input logic [127:0] a2,
                      input logic [15:0] pr, input logic [1:0] sz, input logic uns,
                      input logic [127:0] exp, input string tag);
    @(negedge clk);
    if (p_v[2]) begin
      chk(out_valid === 1'b1, "R7 out_valid high", {127'd0, out_valid}, 128'd1);
      chk(out_vec === p_e[2], p_t[2], out_vec, p_e[2]);
      last_out = p_e[2];
    end else begin
      chk(out_valid === 1'b0, "R7 out_valid low", {127'd0, out_valid}, 128'd0);
      chk(out_vec === last_out, "R9 hold when idle", out_vec, last_out);
    end
    p_v[2] = p_v[1]; p_e[2] = p_e[1]; p_t[2] = p_t[1];
    p_v[1] = p_v[0]; p_e[1] = p_e[0]; p_t[1] = p_t[0];
    p_v[0] = v;      p_e[0] = exp;    p_t[0] = tag;
    in_valid = v; in_op1 = a1; in_op2 = a2; in_pred = pr; in_size = sz; in_unsigned = uns;
  endtask

  task automatic go(input logic [127:0] a1, input logic [127:0] a2, input logic [15:0] pr,
                    input logic [1:0] sz, input logic uns, input string tag);
    step(1'b1, a1, a2, pr, sz, uns, ref_mulh(a1, a2, pr, sz, uns), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, 2'd0, 1'b0, '0, "idle");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin p_v[i] = 1'b0; p_e[i] = '0; p_t[i] = ""; end
    last_out = '0;
    chk(out_valid === 1'b0, "R8 reset out_valid", {127'd0, out_valid}, 128'd0);
    chk(out_vec === '0, "R8 reset out_vec", out_vec, 128'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] a1, a2;
    logic [127:0] ones = {128{1'b1}};
    logic [127:0] mn8  = {16{8'h80}};
    logic [127:0] mn64 = {2{64'h8000_0000_0000_0000}};
    do_reset();

    // R2 / R3: exhaustive 8-bit operand pairs, streamed back to back
    for (int uns = 0; uns < 2; uns++) begin
      for (int i = 0; i < 4096; i++) begin
        for (int j = 0; j < 16; j++) begin
          logic [15:0] idx = 16'(i * 16 + j);
          a1[j*8 +: 8] = idx[15:8];
          a2[j*8 +: 8] = idx[7:0];
        end
        go(a1, a2, 16'hFFFF, 2'd0, 1'(uns), uns != 0 ? "R3 unsigned 8-bit sweep" : "R2 signed 8-bit sweep");
      end
    end
    idle(3);

    // R1: all-ones operands, unsigned, each lane size gives its own pattern
    step(1, ones, ones, 16'hFFFF, 2'd0, 1, {16{8'hFE}}, "R1 size code 0 lanes");
    step(1, ones, ones, 16'hFFFF, 2'd1, 1, {8{16'hFFFE}}, "R1 size code 1 lanes");
    step(1, ones, ones, 16'hFFFF, 2'd2, 1, {4{32'hFFFF_FFFE}}, "R1 size code 2 lanes");
    step(1, ones, ones, 16'hFFFF, 2'd3, 1, {2{64'hFFFF_FFFF_FFFF_FFFE}}, "R1 size code 3 lanes");
    step(1, ones, ones, 16'hFFFF, 2'd3, 0, 128'd0, "R2 signed -1*-1 high half");

    // R6: most negative value squared
    step(1, mn8, mn8, 16'hFFFF, 2'd0, 0, {16{8'h40}}, "R6 8-bit min squared");
    step(1, mn64, mn64, 16'hFFFF, 2'd3, 0, {2{64'h4000_0000_0000_0000}}, "R6 64-bit min squared");
    go({8{16'h8000}}, {8{16'h8000}}, 16'hFFFF, 2'd1, 0, "R6 16-bit min squared");
    go({4{32'h8000_0000}}, {4{32'h8000_0000}}, 16'hFFFF, 2'd2, 0, "R6 32-bit min squared");

    // R4 / R5: only the lowest byte bit of each lane counts
    a1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    step(1, a1, ones, 16'h7E7E, 2'd3, 0, a1, "R4 upper predicate bits ignored, size 3");
    step(1, a1, ones, 16'hEEEE, 2'd2, 0, a1, "R4 upper predicate bits ignored, size 2");
    step(1, a1, a1, 16'h0000, 2'd0, 1, a1, "R5 all lanes inactive merge op1");
    go(a1, ones, 16'h0101, 2'd3, 0, "R4 lead bits set size 3");
    go(a1, a1, 16'h5555, 2'd1, 0, "R5 alternate lanes size 1");
    idle(4);

    // R1..R5: pseudo-random operands, predicates, sizes and modes
    for (int k = 0; k < 1200; k++) begin
      logic [15:0] pr;
      rs = xs(rs); a1[63:0] = rs;  rs = xs(rs); a1[127:64] = rs;
      rs = xs(rs); a2[63:0] = rs;  rs = xs(rs); a2[127:64] = rs;
      rs = xs(rs); pr = rs[15:0];
      go(a1, a2, pr, rs[17:16], rs[20], "R1 random mixed sizes and predicates");
      if (rs[33:31] == 3'd0) idle(1);
    end
    idle(3);

    // R8: reset in the middle of traffic
    go(ones, ones, 16'hFFFF, 2'd0, 1, "R1 pre-reset result");
    idle(3);
    go(ones, ones, 16'hFFFF, 2'd1, 1, "R8 in flight");
    do_reset();
    idle(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule